// File: doc/BRIEF.md
# Decode Group Steering Unit

This unit sits between instruction-length predecode and the legacy decoders. Every cycle it looks at the oldest few predecoded instructions waiting in the instruction queue and forms one decode group. The first instruction of a group always lands in the single complex decoder slot. Up to three further instructions may follow in the simple decoder slots, but only if each produces exactly one uop and carries no "complex only" mark. A load fused with its operation counts as one uop and so qualifies for a simple slot.

The group closes in front of the first instruction that is multi-uop, marked complex-only, or not valid. That instruction leads the next cycle's group in the complex slot. An instruction producing more uops than the complex decoder can emit in one cycle is handed to microcode sequencing. It occupies the complex slot alone, with no simple slots filled behind it.

The queue window is offered as per-entry valid bits with per-entry ready bits back. Ready bits always form a contiguous run from the oldest entry, so instructions leave the queue in program order and none is skipped. One cycle after consumption, the unit presents the slot contents, the instruction count and the uop total for the group. This lets a bench compare front-end throughput across instruction mixes.

Top module: `dgs_steer`

## Requirements
- R1: While `rst` is high, `in_ready` is all zero. On the first clock edge with `rst` high, every output register clears to zero.
- R2: `in_ready` is a contiguous run of ones starting at bit 0 and is a subset of `in_valid`.
- R3: When window entry 0 is valid, it is always consumed into the complex slot (`in_ready[0]` = 1), whatever its uop count or mark.
- R4: Window entry i ≥ 1 is consumed only when it is valid, its extra-uop field `in_xtra[4i+3:4i]` is 0 (one uop, fused memory forms included), its `in_force[i]` is 0, and entry i-1 is also consumed.
- R5: An entry with `in_force` set and a zero extra-uop field is grouped exactly like a multi-uop entry: it closes the group when it is not first.
- R6: A stream made only of complex-steered instructions advances at exactly one instruction per cycle. A stream of only simple instructions advances four per cycle.
- R7: An entry 0 whose uop count (extra field plus one) exceeds 4 is consumed alone. In the following cycle `out_ucode` is 1.
- R8: One cycle after a consumption, `out_valid` is 1, `out_slot_valid` equals the consumed mask, `out_ninstr` equals its population count, and `out_tag` slot i carries the tag of window entry i. Slot 0 is the complex slot.
- R9: One cycle after a consumption, `out_nuops` equals the sum over consumed entries of (extra field + 1).
- R10: With `in_valid[0]` low, nothing is consumed, and the next cycle shows `out_valid` = 0 and `out_ninstr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Valid bit per queue window entry, entry 0 oldest |
| in_xtra | input | 16 | Per entry, uop count minus one (4 bits each) |
| in_force | input | 4 | Per entry, opcode must use the complex decoder |
| in_tag | input | 32 | Per entry, 8-bit instruction tag |
| in_ready | output | 4 | Per entry, consumed this cycle |
| out_valid | output | 1 | A group was formed in the previous cycle |
| out_slot_valid | output | 4 | Occupied slots, bit 0 the complex slot |
| out_tag | output | 32 | Tag per slot, zero when the slot is empty |
| out_ucode | output | 1 | Complex slot holds a microcode-sequenced instruction |
| out_ninstr | output | 3 | Instructions in the group |
| out_nuops | output | 7 | Uops produced by the group |

## Verification
The bench runs whole programs through a queue model and pops as many entries as the unit accepts each cycle. It catches a design that lets a multi-uop or complex-only instruction slip into a simple slot: such a design would report too many instructions per group. It also catches one that skips past a blocked entry: that would break the program-order tag sequence. Directed streams of only complex-only instructions, only single-uop instructions and long microcode instructions must take exactly one, one quarter and one cycle per instruction. A design that packed simple instructions behind a microcode instruction, or that mis-summed uops, shows up in `out_ucode`, `out_ninstr` or `out_nuops` of the group.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

    localparam int XTRA_W      = 4;
    localparam int CX_MAX_UOPS = 4;

    typedef struct packed {
        logic              simple;
        logic              ucode;
        logic [XTRA_W:0]   uops;
    } entry_class_t;

    function automatic logic [XTRA_W:0] uops_of(input logic [XTRA_W-1:0] xtra);
        return {1'b0, xtra} + 1'b1;
    endfunction

endpackage

// File: rtl/dgs_classify.sv
module dgs_classify
    import dgs_pkg::*;
(
    input  logic [XTRA_W-1:0] xtra,
    input  logic              force_cx,
    output entry_class_t      cls
);
    always_comb begin
        cls.uops   = uops_of(xtra);
        cls.simple = (xtra == '0) && !force_cx;
        cls.ucode  = cls.uops > (XTRA_W+1)'(CX_MAX_UOPS);
    end
endmodule

// File: rtl/dgs_group_former.sv
module dgs_group_former
    import dgs_pkg::*;
#(
    parameter int W     = 4,
    parameter int CNT_W = 3,
    parameter int NU_W  = 7
) (
    input  logic               valid [W],
    input  entry_class_t       cls   [W],
    output logic [W-1:0]       take,
    output logic [CNT_W-1:0]   ninstr,
    output logic [NU_W-1:0]    nuops,
    output logic               ucode
);
    always_comb begin
        logic open;
        take    = '0;
        take[0] = valid[0];
        open    = valid[0] && !cls[0].ucode;
        for (int i = 1; i < W; i++) begin
            take[i] = open && valid[i] && cls[i].simple;
            open    = take[i];
        end
    end

    always_comb begin
        ninstr = '0;
        nuops  = '0;
        for (int i = 0; i < W; i++) begin
            if (take[i]) begin
                ninstr = ninstr + 1'b1;
                nuops  = nuops + NU_W'(cls[i].uops);
            end
        end
        ucode = take[0] && cls[0].ucode;
    end
endmodule

// File: rtl/dgs_steer.sv
module dgs_steer
    import dgs_pkg::*;
#(
    parameter  int NUM_SIMPLE = 3,
    parameter  int TAG_W      = 8,
    localparam int W          = NUM_SIMPLE + 1,
    localparam int CNT_W      = $clog2(W + 1),
    localparam int NU_W       = XTRA_W + 1 + $clog2(W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         in_valid,
    input  logic [W*XTRA_W-1:0]  in_xtra,
    input  logic [W-1:0]         in_force,
    input  logic [W*TAG_W-1:0]   in_tag,
    output logic [W-1:0]         in_ready,
    output logic                 out_valid,
    output logic [W-1:0]         out_slot_valid,
    output logic [W*TAG_W-1:0]   out_tag,
    output logic                 out_ucode,
    output logic [CNT_W-1:0]     out_ninstr,
    output logic [NU_W-1:0]      out_nuops
);
    entry_class_t       cls   [W];
    logic               vld   [W];
    logic [W-1:0]       take;
    logic [CNT_W-1:0]   ninstr;
    logic [NU_W-1:0]    nuops;
    logic               ucode;

    for (genvar g = 0; g < W; g++) begin : g_cls
        dgs_classify u_cls (
            .xtra     (in_xtra[g*XTRA_W +: XTRA_W]),
            .force_cx (in_force[g]),
            .cls      (cls[g])
        );
        assign vld[g] = in_valid[g] && !rst;
    end

    dgs_group_former #(.W(W), .CNT_W(CNT_W), .NU_W(NU_W)) u_grp (
        .valid  (vld),
        .cls    (cls),
        .take   (take),
        .ninstr (ninstr),
        .nuops  (nuops),
        .ucode  (ucode)
    );

    assign in_ready = take;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_slot_valid <= '0;
            out_tag        <= '0;
            out_ucode      <= 1'b0;
            out_ninstr     <= '0;
            out_nuops      <= '0;
        end else begin
            out_valid      <= take[0];
            out_slot_valid <= take;
            for (int i = 0; i < W; i++)
                out_tag[i*TAG_W +: TAG_W] <= take[i] ? in_tag[i*TAG_W +: TAG_W] : '0;
            out_ucode      <= ucode;
            out_ninstr     <= ninstr;
            out_nuops      <= nuops;
        end
    end
endmodule

// File: rtl/dgs_steer_chk.sv
module dgs_steer_chk
    import dgs_pkg::*;
#(
    parameter int W     = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 3,
    parameter int NU_W  = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic [W-1:0]         in_valid,
    input logic [W*XTRA_W-1:0]  in_xtra,
    input logic [W-1:0]         in_force,
    input logic [W*TAG_W-1:0]   in_tag,
    input logic [W-1:0]         in_ready,
    input logic                 out_valid,
    input logic [W-1:0]         out_slot_valid,
    input logic [W*TAG_W-1:0]   out_tag,
    input logic                 out_ucode,
    input logic [CNT_W-1:0]     out_ninstr,
    input logic [NU_W-1:0]      out_nuops
);
    always_comb begin
        if (rst) a_r1_no_take_in_reset: assert (in_ready == '0);
    end

    a_r2_subset_of_valid: assert property (@(posedge clk) disable iff (rst)
        (in_ready & ~in_valid) == '0);

    a_r3_head_taken: assert property (@(posedge clk) disable iff (rst)
        in_valid[0] |-> in_ready[0]);

    for (genvar i = 1; i < W; i++) begin : g_slot
        a_r2_prefix: assert property (@(posedge clk) disable iff (rst)
            in_ready[i] |-> in_ready[i-1]);
        a_r4_simple_only: assert property (@(posedge clk) disable iff (rst)
            in_ready[i] |-> (in_xtra[i*XTRA_W +: XTRA_W] == '0 && !in_force[i]));
    end

    a_r7_ucode_alone: assert property (@(posedge clk) disable iff (rst)
        (in_ready[0] && in_xtra[XTRA_W-1:0] >= XTRA_W'(CX_MAX_UOPS)) |-> in_ready[W-1:1] == '0);

    a_r7_ucode_uops: assert property (@(posedge clk) disable iff (rst)
        out_ucode |-> (out_nuops > NU_W'(CX_MAX_UOPS) && out_ninstr == CNT_W'(1)));

    a_r8_count: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_ninstr == CNT_W'($countones($past(in_ready))));

    a_r8_head_tag: assert property (@(posedge clk) disable iff (rst)
        in_ready[0] |=> (out_slot_valid[0] && out_tag[TAG_W-1:0] == $past(in_tag[TAG_W-1:0])));

    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid[0] |=> (!out_valid && out_ninstr == '0));
endmodule

bind dgs_steer dgs_steer_chk #(.W(W), .TAG_W(TAG_W), .CNT_W(CNT_W), .NU_W(NU_W)) u_chk (.*);

// File: tb/dgs_steer_bench.sv
module dgs_steer_bench;
    localparam int W = 4;
    localparam int XW = 4;
    localparam int TW = 8;
    localparam int MAXP = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [W-1:0]    in_valid = '0;
    logic [W*XW-1:0] in_xtra = '0;
    logic [W-1:0]    in_force = '0;
    logic [W*TW-1:0] in_tag = '0;
    logic [W-1:0]    in_ready;
    logic            out_valid;
    logic [W-1:0]    out_slot_valid;
    logic [W*TW-1:0] out_tag;
    logic            out_ucode;
    logic [2:0]      out_ninstr;
    logic [6:0]      out_nuops;

    int n_checks = 0;
    int n_fail   = 0;

    int p_xtra  [MAXP];
    int p_force [MAXP];
    int p_tag   [MAXP];

    always #10 clk = ~clk;

    dgs_steer u_dgs_steer (.*);

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int exp_take(input int n, input int head);
        int k;
        if (head >= n) return 0;
        k = 1;
        if (p_xtra[head] >= 4) return 1;
        for (int i = 1; i < W; i++) begin
            if (head + i < n && p_xtra[head+i] == 0 && p_force[head+i] == 0) k++;
            else break;
        end
        return k;
    endfunction

    task automatic run_prog(input int n, output int cycles);
        int head = 0;
        cycles = 0;
        while (head < n) begin
            int k, nu;
            bit uc;
            @(negedge clk);
            for (int w = 0; w < W; w++) begin
                in_valid[w]          = (head + w < n);
                in_xtra[w*XW +: XW]  = (head + w < n) ? XW'(p_xtra[head+w]) : '0;
                in_force[w]          = (head + w < n) ? p_force[head+w][0] : 1'b0;
                in_tag[w*TW +: TW]   = (head + w < n) ? TW'(p_tag[head+w]) : '0;
            end
            #1;
            k = exp_take(n, head);
            nu = 0;
            for (int j = 0; j < k; j++) nu += p_xtra[head+j] + 1;
            uc = (p_xtra[head] >= 4);
            // R2 R3 R4 R5 R7: consumed mask is the expected prefix
            check(in_ready == W'((1 << k) - 1), "R4 in_ready", in_ready, (1 << k) - 1);
            @(posedge clk);
            #1;
            check(out_valid == 1'b1, "R8 out_valid", out_valid, 1);
            check(out_ninstr == 3'(k), "R8 out_ninstr", out_ninstr, k);
            check(out_nuops == 7'(nu), "R9 out_nuops", out_nuops, nu);
            check(out_ucode == uc, "R7 out_ucode", out_ucode, uc);
            for (int j = 0; j < k; j++)
                check(out_tag[j*TW +: TW] == TW'(p_tag[head+j]), "R8 out_tag",
                      out_tag[j*TW +: TW], p_tag[head+j] & 8'hff);
            head += k;
            cycles++;
        end
        @(negedge clk);
        in_valid = '0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_ninstr == 3'd0, "R10 idle", out_ninstr, 0);
    endtask

    task automatic fill(input int n, input int kind, input int tbase);
        for (int i = 0; i < n; i++) begin
            p_tag[i] = (tbase + i) & 8'hff;
            case (kind)
                0: begin p_xtra[i] = 0; p_force[i] = 1; end
                1: begin p_xtra[i] = 0; p_force[i] = 0; end
                2: begin p_xtra[i] = 5 + (i % 3); p_force[i] = 0; end
                default: begin
                    int r = $urandom % 8;
                    p_xtra[i]  = (r < 5) ? 0 : (r < 7) ? 1 + ($urandom % 3) : 4 + ($urandom % 6);
                    p_force[i] = ($urandom % 6 == 0) ? 1 : 0;
                end
            endcase
        end
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd1729));
        in_valid = '1;
        #1;
        check(in_ready == '0, "R1 ready in reset", in_ready, 0);
        @(posedge clk);
        @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_ninstr == '0 && out_nuops == '0, "R1 reset outputs", out_nuops, 0);
        @(negedge clk);
        in_valid = '0;
        rst = 1'b0;

        // R6 R5: complex-only single-uop stream, one per cycle
        fill(12, 0, 16);
        run_prog(12, cyc);
        check(cyc == 12, "R6 complex stream cycles", cyc, 12);

        // R6: simple stream, four per cycle
        fill(12, 1, 48);
        run_prog(12, cyc);
        check(cyc == 3, "R6 simple stream cycles", cyc, 3);

        // R7: microcode instructions occupy the group alone
        fill(6, 2, 80);
        run_prog(6, cyc);
        check(cyc == 6, "R7 microcode cycles", cyc, 6);

        // directed: multi-uop in slot 2 closes the group (R4)
        fill(8, 1, 100);
        p_xtra[2] = 2;
        p_force[5] = 1;
        run_prog(8, cyc);
        check(cyc == 3, "R4 R5 directed cycles", cyc, 3);

        // random mixes
        for (int t = 0; t < 8; t++) begin
            fill(60, 3, 32 * t);
            run_prog(60, cyc);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule